// File: doc/BRIEF.md
# Oversampling Baud Tick Generator

This block turns a fast system clock into the two timing strobes that a serial receiver and transmitter need. A programmable modulo-N prescaler produces an oversampling strobe at sixteen times the target bit rate. A second stage counts those strobes modulo sixteen and produces a bit-rate strobe. Both strobes are clock enables, high for one system clock. They are not derived clocks. The divisor is worked out offline as the system frequency divided by sixteen times the baud rate, rounded to an integer. The rounding error must stay within a few percent. For example, 16 MHz at 9600 baud gives a divisor of 104.

The prescaler is a two-state machine. `PS_COUNT` is the normal state. It counts cycles and wraps at the latched divisor minus one. `PS_FLAT` is used when the latched divisor is 0 or 1, and it emits a strobe on every cycle. The transitions are named `T_WRAP_COUNT` (a wrap that enters or stays in `PS_COUNT`) and `T_WRAP_FLAT` (a wrap that enters or stays in `PS_FLAT`). They are taken only at a period boundary. At that boundary the divisor input is sampled again. Synchronous reset loads the state and the divisor directly, from the divisor value present at that moment. A 4-bit phase output tells downstream sampling logic which oversampling slot within the current bit is active.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high, and in the sample taken right after the last reset edge, `os_tick` and `bit_tick` are 0 and `os_phase` is 0.
- R2: For an effective divisor N of 2 or more, each `os_tick` pulse lasts exactly one clock cycle.
- R3: For N of 2 or more, the first `os_tick` is high after the N-th rising edge following reset release, and later pulses come every N cycles.
- R4: A divisor value of 0 or 1 is treated as 1, and `os_tick` is then high on every cycle, starting after the first edge following reset release.
- R5: A change on `divisor` does not alter the period in progress. The new value is sampled at the edge where a period wraps and governs the next period. This includes switching into and out of the every-cycle mode.
- R6: `bit_tick` is high in the same cycle as every sixteenth `os_tick`, namely the one whose phase is 15. The first `bit_tick` coincides with the sixteenth `os_tick` after reset.
- R7: During the k-th `os_tick` since reset (k counted from 1), `os_phase` equals (k-1) mod 16. It advances by one after each `os_tick`, wraps from 15 to 0, and holds between strobes.
- R8: Divisors above 255 (the default width is 16 bits) divide correctly. For example, 300 gives one `os_tick` every 300 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| divisor | input | DIV_W (16) | Oversampling divisor N; 0 and 1 mean every cycle |
| os_tick | output | 1 | One-cycle oversampling strobe, registered |
| bit_tick | output | 1 | One-cycle bit-rate strobe, coincident with the 16th oversampling strobe |
| os_phase | output | PH_W (4) | Index of the current oversampling slot within the bit |

## Verification
Two events can land in the same cycle: a prescaler wrap that samples a new divisor, and the oversampling strobe that also carries the bit strobe. The bench provokes the first by changing `divisor` several cycles before a wrap and also in the cycle just before a wrap. It covers switches into and out of the every-cycle mode. Each strobe time is compared against a schedule computed by hand. The second case is judged by sweeping divisors 0 to 24, 104 and 300 over two full bits. For every cycle, the expected `os_tick`, `bit_tick` and `os_phase` are computed arithmetically from the edge count.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [0:0] {
        PS_COUNT = 1'b0,
        PS_FLAT  = 1'b1
    } ps_state_e;

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    ps_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] lim_q, lim_d;
    logic             tick_q, tick_d;
    logic [DIV_W-1:0] eff_div;
    ps_state_e        entry_state;

    // divisor of 0 or 1 collapses to a one-cycle period
    assign eff_div     = (divisor <= ONE) ? ONE : divisor;
    assign entry_state = (eff_div == ONE) ? PS_FLAT : PS_COUNT;

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        tick_d  = 1'b0;
        unique case (state_q)
            PS_COUNT: begin
                if (cnt_q == lim_q - ONE) begin
                    // T_WRAP_COUNT / T_WRAP_FLAT
                    cnt_d   = '0;
                    lim_d   = eff_div;
                    state_d = entry_state;
                    tick_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            PS_FLAT: begin
                cnt_d   = '0;
                lim_d   = eff_div;
                state_d = entry_state;
                tick_d  = 1'b1;
            end
            default: begin
                state_d = PS_COUNT;
                cnt_d   = '0;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= entry_state;
            cnt_q   <= '0;
            lim_q   <= eff_div;
            tick_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
            tick_q  <= tick_d;
        end
    end

    assign tick = tick_q;

    // R2: a strobe is never followed by another when the new period is 2 or more
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (tick_q && state_q == PS_COUNT && lim_q >= DIV_W'(2)) |=> !tick_q);

    // R3: the count stays inside the latched period
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_COUNT) |-> (cnt_q < lim_q));

    // R4: the every-cycle state always yields a strobe on the next edge
    a_r4_flat_tick: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_FLAT) |=> tick_q);

    // R5: the latched period holds until a wrap
    a_r5_hold_midperiod: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_COUNT && cnt_q != lim_q - ONE) |=> $stable(lim_q));

endmodule

// File: rtl/baud_bit_stage.sv
module baud_bit_stage #(
    parameter int OSR  = 16,
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            os_tick,
    output logic            bit_tick,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] LAST = PH_W'(OSR - 1);

    logic [PH_W-1:0] ph_q;

    generate
        if (OSR > 1) begin : g_count
            always_ff @(posedge clk) begin
                if (rst) begin
                    ph_q <= '0;
                end else if (os_tick) begin
                    ph_q <= (ph_q == LAST) ? '0 : ph_q + PH_W'(1);
                end
            end
            assign bit_tick = os_tick && (ph_q == LAST);
        end else begin : g_pass
            always_ff @(posedge clk) begin
                ph_q <= '0;
            end
            assign bit_tick = os_tick;
        end
    endgenerate

    assign phase = ph_q;

    // R7: phase holds between strobes
    a_r7_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !os_tick |=> $stable(ph_q));

    // R7: phase steps by one after a strobe that is not the last slot
    a_r7_phase_step: assert property (@(posedge clk) disable iff (rst)
        (os_tick && ph_q != LAST) |=> (ph_q == PH_W'($past(ph_q) + PH_W'(1))));

    // R6: after a bit strobe the next bit starts at slot 0
    a_r6_bit_restart: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> (ph_q == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OSR   = 16,
    parameter int PH_W  = (OSR > 1) ? $clog2(OSR) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             os_tick,
    output logic             bit_tick,
    output logic [PH_W-1:0]  os_phase
);

    logic os_tick_w;

    baud_prescaler #(.DIV_W(DIV_W)) u_prescaler (
        .clk     (clk),
        .rst     (rst),
        .divisor (divisor),
        .tick    (os_tick_w)
    );

    baud_bit_stage #(.OSR(OSR), .PH_W(PH_W)) u_bit_stage (
        .clk      (clk),
        .rst      (rst),
        .os_tick  (os_tick_w),
        .bit_tick (bit_tick),
        .phase    (os_phase)
    );

    assign os_tick = os_tick_w;

    // R1: outputs are quiet in the cycle following a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!os_tick && !bit_tick && os_phase == '0));

endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

    localparam int DIV_W = 16;
    localparam int OSR   = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] divisor = DIV_W'(4);
    logic             os_tick, bit_tick;
    logic [3:0]       os_phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk      (clk),
        .rst      (rst),
        .divisor  (divisor),
        .os_tick  (os_tick),
        .bit_tick (bit_tick),
        .os_phase (os_phase)
    );

    task automatic chk(input string req, input int act, input int exp, input int n, input int c);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s N=%0d cycle=%0d actual=%0d expected=%0d", req, n, c, act, exp);
        end
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        divisor = DIV_W'(n);
        repeat (2) begin
            @(posedge clk); #1;
            chk("R1 os_tick", int'(os_tick), 0, n, 0);
            chk("R1 bit_tick", int'(bit_tick), 0, n, 0);
            chk("R1 os_phase", int'(os_phase), 0, n, 0);
        end
        rst = 1'b0;
    endtask

    // full schedule check for a fixed divisor
    task automatic sweep(input int n);
        int eff;
        int k;
        eff = (n <= 1) ? 1 : n;
        do_reset(n);
        for (int c = 1; c <= eff * OSR * 2 + 3; c++) begin
            bit eo, eb;
            int ep;
            @(posedge clk); #1;
            eo = (c % eff) == 0;
            k  = c / eff;
            ep = eo ? (k - 1) % OSR : k % OSR;
            eb = eo && (((k - 1) % OSR) == OSR - 1);
            chk(eff == 1 ? "R4 os_tick" : (n > 255 ? "R8 os_tick" : "R3 os_tick"), int'(os_tick), int'(eo), n, c);
            chk("R6 bit_tick", int'(bit_tick), int'(eb), n, c);
            chk("R7 os_phase", int'(os_phase), ep, n, c);
        end
    endtask

    // divisor change mid-run: n0 from reset, n1 applied after edge 'at'
    task automatic change_run(input int n0, input int at, input int n1, input int at2, input int n2,
                              input int t0, input int t1, input int t2, input int t3, input int t4,
                              input int last);
        do_reset(n0);
        for (int c = 1; c <= last; c++) begin
            bit eo;
            @(posedge clk); #1;
            eo = (c == t0) || (c == t1) || (c == t2) || (c == t3) || (c == t4);
            chk("R5 os_tick", int'(os_tick), int'(eo), n0, c);
            if (eo) chk("R2 os_tick width", int'(os_tick), 1, n0, c);
            if (c == at)  divisor = DIV_W'(n1);
            if (c == at2) divisor = DIV_W'(n2);
        end
    endtask

    initial begin
        for (int n = 0; n <= 24; n++) sweep(n);
        sweep(104);
        sweep(300);
        // change well before wrap: 10 -> 3
        change_run(10, 4, 3, 100, 3, 10, 13, 16, 19, 22, 23);
        // change in the cycle just before wrap: 5 -> 2
        change_run(5, 4, 2, 100, 2, 5, 7, 9, 11, 13, 14);
        // into every-cycle mode and back out: 4 -> 0 -> 3
        change_run(4, 2, 0, 5, 3, 4, 5, 6, 9, 12, 14);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule